// File: doc/BRIEF.md
# Peripheral Window Base Decoder

This block owns a single 16-bit base register and the comparator that goes with it. Together they place a 4 KB window of on-chip peripherals at any 4 KB-aligned spot in a 24-bit address space. For each bus access the comparator reports whether the address falls in the window and gives the byte offset inside it. The match can optionally also require the 3-bit bus-cycle space code to equal a code held in the register.

The register has a fixed address and only answers in the supervisor-data space. After a full reset it reads back a preset value, but the window stays dead until software has written the register's low byte. It accepts both a 16-bit bus with byte enables and an 8-bit bus where the two bytes sit at consecutive addresses.

An external device may also claim an access that lands inside the window. When that happens the block latches a sticky conflict flag. If the conflict-error enable input is high, it also raises a bus error in the same cycle.

Top module: `periph_window_decoder`

## Requirements
- R1: After a full reset the register reads 0xBFFF, the conflict flag is 0, and no address produces a window hit.
- R2: The register is selected only when `bus_valid` is 1, the space code is 5 and address bits 23..1 equal 0x0F2 >> 1. Writes anywhere else, or in any other space, leave it unchanged. On a 16-bit bus, `bus_be[1]` writes bits 15..8 from `bus_wdata[15:8]` and `bus_be[0]` writes bits 7..0 from `bus_wdata[7:0]`.
- R3: The window stays disabled until the register's low byte (bits 7..0) has been written. Writing only the high byte does not enable it.
- R4: With the window enabled and `bus_valid` = 1, a hit requires address bits 23..12 to equal register bits 11..0. With `bus_valid` = 0 there is never a hit.
- R5: Register bit 12 is the space-compare enable. At 0 the space code does not affect the hit. At 1 the space code must also equal register bits 15..13.
- R6: Space code 7 never produces a hit, whatever the register holds.
- R7: `win_offset` equals address bits 11..0 while `win_hit` is 1, and 0 otherwise.
- R8: A cycle with `win_hit` and `ext_claim` both 1 sets `conflict_flag` at the next clock edge. The flag then stays set until a full reset. `ext_claim` on a miss does not set it.
- R9: `bus_err` is 1 in the same cycle exactly when `win_hit`, `ext_claim` and `conflict_err_en` are all 1.
- R10: In 8-bit mode (`mode_8bit` = 1) address 0x0F2 carries bits 15..8 and 0x0F3 carries bits 7..0. Both are written from `bus_wdata[7:0]` and `bus_be` is ignored. Reads return the selected byte on `bus_rdata[7:0]` with the upper byte 0. On a 16-bit bus reads return the full register. When the register is not selected, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full system reset, asynchronous active low |
| mode_8bit | input | 1 | 1 = 8-bit bus byte addressing, static |
| bus_valid | input | 1 | Access in progress |
| bus_addr | input | 24 | Access address |
| bus_space | input | 3 | Bus-cycle space code |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte enables, 16-bit mode |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Register read data |
| ext_claim | input | 1 | External device also decodes this access |
| conflict_err_en | input | 1 | Allow bus error on conflict |
| win_hit | output | 1 | Access falls in the peripheral window |
| win_offset | output | 12 | Offset within the window |
| conflict_flag | output | 1 | Sticky overlap indication |
| bus_err | output | 1 | Bus error for a conflicting access |

## Verification
The bench sweeps every 12-bit base field against every space code. A comparator off by one bit, or one that lets space 7 through, shows up as a stray or missing hit at a specific base. Straight after reset it probes the reset value 0xFFF as a base, which catches a design that treats the preset value as written. It then writes only the high byte, which catches a design that enables the window on any write. The space-compare flag is exercised with codes 0, 3 and 7 to catch an inverted enable. On the 8-bit bus, swapped byte addresses would put the base in the wrong half of the register. Finally it checks that a claim on a miss leaves the conflict flag clear and that the bus error respects its enable, which catches a flag set on any claim.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int unsigned SPACE_W = 3;
  typedef logic [SPACE_W-1:0] space_t;
  localparam space_t SPACE_SUP_DATA = 3'd5;
  localparam space_t SPACE_INT_ACK  = 3'd7;
  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/pwd_base_reg.sv
module pwd_base_reg
  import pwd_pkg::*;
#(
  parameter int unsigned REG_W     = 16,
  parameter logic [15:0] RESET_VAL = 16'hBFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_mode,
  input  logic             sel,
  input  logic             wr,
  input  logic             addr0,
  input  logic [1:0]       be,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] reg_q,
  output logic             valid_q,
  output logic [REG_W-1:0] rdata
);
  localparam int unsigned NLANES = REG_W / LANE_W;

  logic [REG_W-1:0]  reg_d;
  logic [NLANES-1:0] wr_lane;
  logic              valid_d;

  for (genvar b = 0; b < NLANES; b++) begin : g_lane
    logic [LANE_W-1:0] src;
    assign wr_lane[b] = sel & wr & (byte_mode ? (addr0 == (b == 0)) : be[b]);
    assign src = byte_mode ? wdata[LANE_W-1:0] : wdata[LANE_W*b +: LANE_W];
    assign reg_d[LANE_W*b +: LANE_W] = wr_lane[b] ? src : reg_q[LANE_W*b +: LANE_W];
  end

  always_comb begin
    valid_d = valid_q | wr_lane[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q   <= RESET_VAL[REG_W-1:0];
      valid_q <= 1'b0;
    end else begin
      if (|wr_lane) reg_q <= reg_d;
      if (wr_lane[0]) valid_q <= valid_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      if (byte_mode) rdata[LANE_W-1:0] = addr0 ? reg_q[LANE_W-1:0] : reg_q[REG_W-1 -: LANE_W];
      else           rdata = reg_q;
    end
  end

  // R2: register keeps its value when no selected write occurs
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr) |=> reg_q == $past(reg_q));
  // R3: once enabled the window stays enabled until reset
  a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);
  // R3: enabling requires a write cycle
  a_r3_valid_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr) |=> $stable(valid_q));
endmodule

// File: rtl/pwd_window_match.sv
module pwd_window_match
  import pwd_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFS_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enabled,
  input  logic                    bus_valid,
  input  logic [ADDR_W-1:0]       addr,
  input  space_t                  space,
  input  logic [ADDR_W-OFS_W-1:0] base,
  input  logic                    cmp_en,
  input  space_t                  code,
  output logic                    hit,
  output logic [OFS_W-1:0]        offset
);
  logic base_eq;
  logic space_ok;

  always_comb begin
    base_eq  = (addr[ADDR_W-1:OFS_W] == base);
    space_ok = (!cmp_en || (space == code)) && (space != SPACE_INT_ACK);
    hit      = bus_valid && enabled && base_eq && space_ok;
    offset   = hit ? addr[OFS_W-1:0] : '0;
  end

  // R6: interrupt-acknowledge cycles never hit
  a_r6_intack_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (space == SPACE_INT_ACK) |-> !hit);
  // R3: no hit before the register is written
  a_r3_no_hit_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !hit);
  // R7: offset is zero on a miss
  a_r7_offset_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> offset == '0);
endmodule

// File: rtl/pwd_conflict.sv
module pwd_conflict (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ext_claim,
  input  logic err_en,
  output logic flag_q,
  output logic bus_err
);
  logic overlap;
  logic flag_d;

  always_comb begin
    overlap = hit & ext_claim;
    flag_d  = flag_q | overlap;
    bus_err = overlap & err_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (overlap) flag_q <= flag_d;
  end

  // R8: flag is sticky
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);
  // R8: an overlapping access sets the flag
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ext_claim) |=> flag_q);
  // R9: bus error only with enable and a hit
  a_r9_err_gated: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (err_en && hit && ext_claim));
endmodule

// File: rtl/periph_window_decoder.sv
module periph_window_decoder
  import pwd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned OFS_W     = 12,
  parameter logic [23:0] REG_ADDR  = 24'h0000F2,
  parameter logic [15:0] RESET_VAL = 16'hBFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_8bit,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_space,
  input  logic              bus_wr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              ext_claim,
  input  logic              conflict_err_en,
  output logic              win_hit,
  output logic [OFS_W-1:0]  win_offset,
  output logic              conflict_flag,
  output logic              bus_err
);
  localparam int unsigned BASE_W = ADDR_W - OFS_W;
  localparam int unsigned REG_W  = SPACE_W + 1 + BASE_W;

  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic             reg_sel;
  logic [REG_W-1:0] reg_q;
  logic             win_enabled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  always_comb begin
    reg_sel = bus_valid && (bus_space == SPACE_SUP_DATA) &&
              (bus_addr[ADDR_W-1:1] == REG_ADDR[ADDR_W-1:1]);
  end

  pwd_base_reg #(.REG_W(REG_W), .RESET_VAL(RESET_VAL)) u_reg (
    .clk(clk), .rst_n(rst_core_n), .byte_mode(mode_8bit), .sel(reg_sel),
    .wr(bus_wr), .addr0(bus_addr[0]), .be(bus_be), .wdata(bus_wdata),
    .reg_q(reg_q), .valid_q(win_enabled), .rdata(bus_rdata)
  );

  pwd_window_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_match (
    .clk(clk), .rst_n(rst_core_n), .enabled(win_enabled), .bus_valid(bus_valid),
    .addr(bus_addr), .space(bus_space), .base(reg_q[BASE_W-1:0]),
    .cmp_en(reg_q[BASE_W]), .code(reg_q[REG_W-1 -: SPACE_W]),
    .hit(win_hit), .offset(win_offset)
  );

  pwd_conflict u_conf (
    .clk(clk), .rst_n(rst_core_n), .hit(win_hit), .ext_claim(ext_claim),
    .err_en(conflict_err_en), .flag_q(conflict_flag), .bus_err(bus_err)
  );

  // R4: no hit without an active access
  a_r4_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_core_n)
    !bus_valid |-> !win_hit);
endmodule

// File: tb/periph_window_decoder_tb_top.sv
module periph_window_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_8bit;
  logic        bus_valid;
  logic [23:0] bus_addr;
  logic [2:0]  bus_space;
  logic        bus_wr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        ext_claim;
  logic        conflict_err_en;
  logic        win_hit;
  logic [11:0] win_offset;
  logic        conflict_flag;
  logic        bus_err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .mode_8bit(mode_8bit), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_space(bus_space), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_claim(ext_claim),
    .conflict_err_en(conflict_err_en), .win_hit(win_hit), .win_offset(win_offset),
    .conflict_flag(conflict_flag), .bus_err(bus_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic idle();
    bus_valid = 0; bus_wr = 0; bus_be = 2'b00; bus_wdata = 0;
    bus_addr = 0; bus_space = 0; ext_claim = 0; conflict_err_en = 0;
  endtask

  task automatic do_reset(input logic m8);
    @(negedge clk);
    idle();
    mode_8bit = m8;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(input logic [23:0] a, input logic [2:0] s, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1; bus_wr = 1; bus_addr = a; bus_space = s; bus_be = be; bus_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic read_reg(input logic [23:0] a, input logic [2:0] s, input logic [15:0] exp, input string req);
    bus_valid = 1; bus_wr = 0; bus_addr = a; bus_space = s;
    #1;
    chk(bus_rdata == exp, req, {16'h0, bus_rdata}, {16'h0, exp});
    idle();
    #1;
  endtask

  // Sweep all bases and space codes; expected hit from the register image.
  task automatic sweep(input logic [15:0] regv, input logic en, input string req);
    for (int t = 0; t < 4096; t++) begin
      for (int s = 0; s < 8; s++) begin
        logic exp_hit;
        logic [11:0] ofs;
        ofs = 12'((t * 37 + s * 511) & 12'hFFF);
        exp_hit = en && (t[11:0] == regv[11:0]) && (s != 7) &&
                  (!regv[12] || (s[2:0] == regv[15:13]));
        bus_valid = 1; bus_addr = {t[11:0], ofs}; bus_space = s[2:0];
        #1;
        chk(win_hit == exp_hit, req, {31'h0, win_hit}, {31'h0, exp_hit});
        chk(win_offset == (exp_hit ? ofs : 12'h0), "R7 offset", {20'h0, win_offset},
            {20'h0, exp_hit ? ofs : 12'h0});
      end
    end
    idle();
    #1;
  endtask

  initial begin
    rst_n = 0;
    mode_8bit = 0;
    idle();
    do_reset(1'b0);

    // R1 reset state
    read_reg(24'h0000F2, 3'd5, 16'hBFFF, "R1 reset value");
    chk(conflict_flag == 0, "R1 flag reset", {31'h0, conflict_flag}, 0);
    sweep(16'hBFFF, 1'b0, "R1 no hit before write");

    // R2 wrong space / wrong address leave register alone
    do_write(24'h0000F2, 3'd4, 2'b11, 16'h1234);
    read_reg(24'h0000F2, 3'd5, 16'hBFFF, "R2 wrong space write");
    do_write(24'h0000F4, 3'd5, 2'b11, 16'h1234);
    read_reg(24'h0000F2, 3'd5, 16'hBFFF, "R2 wrong address write");
    read_reg(24'h0000F2, 3'd4, 16'h0000, "R10 unselected read zero");

    // R3 high byte only keeps window disabled
    do_write(24'h0000F2, 3'd5, 2'b10, 16'h0300);
    read_reg(24'h0000F2, 3'd5, 16'h03FF, "R2 high lane write");
    sweep(16'h03FF, 1'b0, "R3 high byte only");

    // R2/R3 low byte enables
    do_write(24'h0000F2, 3'd5, 2'b01, 16'h0045);
    read_reg(24'h0000F2, 3'd5, 16'h0345, "R2 low lane write");
    sweep(16'h0345, 1'b1, "R4 base match, space ignored");

    // R4 idle access
    bus_valid = 0; bus_addr = 24'h345123; bus_space = 3'd5;
    #1;
    chk(win_hit == 0, "R4 no hit when idle", {31'h0, win_hit}, 0);
    idle();

    // R5 space compare
    do_write(24'h0000F2, 3'd5, 2'b11, 16'h7345);
    sweep(16'h7345, 1'b1, "R5 space compare code 3");
    do_write(24'h0000F2, 3'd5, 2'b11, 16'h1345);
    sweep(16'h1345, 1'b1, "R5 space compare code 0");
    // R6 stored code 7 with compare: no hit at all
    do_write(24'h0000F2, 3'd5, 2'b11, 16'hF345);
    sweep(16'hF345, 1'b1, "R6 intack never hits");

    // R8/R9 conflict
    do_write(24'h0000F2, 3'd5, 2'b11, 16'h0345);
    @(negedge clk);
    bus_valid = 1; bus_addr = 24'h346010; bus_space = 3'd5; ext_claim = 1; conflict_err_en = 1;
    #1;
    chk(bus_err == 0, "R9 no error on miss", {31'h0, bus_err}, 0);
    @(posedge clk); #1;
    chk(conflict_flag == 0, "R8 claim on miss ignored", {31'h0, conflict_flag}, 0);
    @(negedge clk);
    bus_addr = 24'h345010; conflict_err_en = 0;
    #1;
    chk(bus_err == 0, "R9 error disabled", {31'h0, bus_err}, 0);
    @(posedge clk); #1;
    chk(conflict_flag == 1, "R8 flag set on overlap", {31'h0, conflict_flag}, 1);
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    chk(conflict_flag == 1, "R8 flag sticky", {31'h0, conflict_flag}, 1);
    bus_valid = 1; bus_addr = 24'h345FFE; bus_space = 3'd1; ext_claim = 1; conflict_err_en = 1;
    #1;
    chk(bus_err == 1, "R9 error enabled", {31'h0, bus_err}, 1);
    ext_claim = 0;
    #1;
    chk(bus_err == 0, "R9 no claim no error", {31'h0, bus_err}, 0);
    idle();

    // R10 8-bit bus
    do_reset(1'b1);
    chk(conflict_flag == 0, "R1 flag cleared by reset", {31'h0, conflict_flag}, 0);
    read_reg(24'h0000F2, 3'd5, 16'h00BF, "R10 read high byte");
    read_reg(24'h0000F3, 3'd5, 16'h00FF, "R10 read low byte");
    do_write(24'h0000F2, 3'd5, 2'b00, 16'hAA05);
    read_reg(24'h0000F2, 3'd5, 16'h0005, "R10 write high byte");
    bus_valid = 1; bus_addr = 24'h5FF123; bus_space = 3'd5;
    #1;
    chk(win_hit == 0, "R3 8-bit high byte only", {31'h0, win_hit}, 0);
    idle();
    do_write(24'h0000F3, 3'd5, 2'b00, 16'h0067);
    read_reg(24'h0000F3, 3'd5, 16'h0067, "R10 write low byte");
    read_reg(24'h0000F2, 3'd5, 16'h0005, "R10 high byte kept");
    bus_valid = 1; bus_addr = 24'h567ABC; bus_space = 3'd2;
    #1;
    chk(win_hit == 1, "R4 8-bit enabled hit", {31'h0, win_hit}, 1);
    chk(win_offset == 12'hABC, "R7 8-bit offset", {20'h0, win_offset}, 32'hABC);
    idle();
    #1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule